// File: doc/BRIEF.md
# Itoh-Tsujii Field Inverter

This block finds the multiplicative inverse of an element of the binary field GF(2^M), with elements in polynomial basis. By Fermat's little theorem the inverse equals a^(2^M - 2). Squaring is linear in this field, so the block builds that power without a general exponentiator. It walks an addition chain for M-1 and holds a running value of the form a^(2^u - 1). Each chain step raises the running value to 2^k with a cascade of squaring stages, called the power block. A bit-serial field multiplier then joins the result with a stored term. One last squaring after the final step gives the inverse.

The chain is a parameter. It is stored as one bit per step: a step either doubles u, or adds one to u by using the operand itself as the second term. The power block holds NSTG stages, and a select input picks how many of them the value passes through. A shift longer than NSTG takes several passes. If QUAD is set, each stage computes a fourth power instead of a square. The chain then only has to reach (M-1)/2, and one extra multiply at the start forms a^3. With a zero operand every step yields zero, so the output is zero.

The caller pulses `start` with the operand on `a_in`. After a fixed number of cycles, `done` pulses for one cycle and `inv_out` holds the result.

Top module: `gf_itoh_inverter`

## Requirements
- R1: While reset is held, and after it is released, `done` is 0 and `inv_out` is all zeros.
- R2: For any nonzero operand a, the field product a · `inv_out` equals 1. The product is taken modulo the reduction polynomial x^233 + x^74 + 1 (default parameters, bit i = coefficient of x^i).
- R3: An operand of zero gives an `inv_out` of zero.
- R4: An operand of 1 gives 1. An operand x (value 2) gives x^232 + x^73, which is bits 232 and 73 set.
- R5: `done` is high for exactly one cycle per completed inversion. `inv_out` changes only in the cycle in which `done` is high, and it then holds until the next completion.
- R6: The number of cycles from accepting `start` to `done` is the same for every operand, including zero and one.
- R7: A `start` pulse that arrives while an inversion is running is ignored. The running result and its timing are unchanged.
- R8: A `start` pulse that arrives in the same cycle as `done` is accepted. That inversion completes with the usual latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that starts an inversion when the block is idle |
| a_in | input | M | Operand, sampled with an accepted `start` |
| inv_out | output | M | Inverse of the last operand, held between completions |
| done | output | 1 | One-cycle pulse when `inv_out` is updated |

## Verification
Two events can fall in the same cycle: the completion pulse of one inversion and the start request of the next. After the block finishes it returns to idle at the same clock edge, so a request that arrives while `done` is high must be taken rather than dropped. The bench provokes this by raising `start` with a fresh operand in the cycle in which it sees `done`. It then checks both results against the product rule, and checks that the second latency equals the one measured for a lone inversion. A related case is a request that arrives mid-computation. That request must leave both the operand and the timing of the running inversion unchanged.

// File: rtl/gf_itoh_inverter.sv
module gf_itoh_inverter #(
  parameter int          M         = 233,
  parameter logic [M-1:0] POLY_LOW = (M'(1) << 74) | M'(1),
  parameter bit          QUAD      = 1'b0,
  parameter int          NSTG      = 11,
  parameter int          CHAIN_LEN = 10,
  parameter logic [31:0] CHAIN_OPS = 32'h0000_03B5
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] a_in,
  output logic [M-1:0] inv_out,
  output logic         done
);
  localparam int UW   = $clog2(M + 1);
  localparam int BW   = $clog2(M);
  localparam int SW   = $clog2(CHAIN_LEN + 1);
  localparam int SELW = $clog2(NSTG + 1);
  localparam logic [UW-1:0] TARGET = QUAD ? UW'((M - 1) / 2) : UW'(M - 1);

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_POW, S_MUL, S_FIN} st_t;

  function automatic logic [M-1:0] gf_sq(input logic [M-1:0] v);
    logic [2*M-2:0] t;
    t = '0;
    for (int i = 0; i < M; i++) t[2*i] = v[i];
    for (int i = 2*M-2; i >= M; i--)
      if (t[i]) t[i-M +: M] = t[i-M +: M] ^ POLY_LOW;
    return t[M-1:0];
  endfunction

  st_t            state;
  logic [M-1:0]   acc, base, pw, mop, r;
  logic [UW-1:0]  u, rem;
  logic [SW-1:0]  step;
  logic [BW-1:0]  bi;
  logic           init_q;

  logic [M-1:0] stg [0:NSTG];
  assign stg[0] = pw;
  for (genvar g = 1; g <= NSTG; g++) begin : g_pow
    if (QUAD) begin : g_quad
      assign stg[g] = gf_sq(gf_sq(stg[g-1]));
    end else begin : g_sqr
      assign stg[g] = gf_sq(stg[g-1]);
    end
  end

  logic           cur_dbl;
  logic [UW-1:0]  n_pass;
  logic [M-1:0]   pw_next, r_next;

  assign cur_dbl = CHAIN_OPS[step];
  assign n_pass  = (rem > UW'(NSTG)) ? UW'(NSTG) : rem;
  assign pw_next = stg[SELW'(n_pass)];
  assign r_next  = {r[M-2:0], 1'b0} ^ (r[M-1] ? POLY_LOW : '0) ^ (mop[bi] ? pw : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      inv_out <= '0;
      acc     <= '0;
      base    <= '0;
      pw      <= '0;
      mop     <= '0;
      r       <= '0;
      u       <= '0;
      rem     <= '0;
      step    <= '0;
      bi      <= '0;
      init_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          base <= a_in;
          acc  <= a_in;
          u    <= UW'(1);
          step <= '0;
          if (QUAD) begin
            pw     <= gf_sq(a_in);
            mop    <= a_in;
            r      <= '0;
            bi     <= BW'(M - 1);
            init_q <= 1'b1;
            state  <= S_MUL;
          end else begin
            state <= S_PREP;
          end
        end
        S_PREP: begin
          pw    <= acc;
          rem   <= cur_dbl ? u : UW'(1);
          mop   <= cur_dbl ? acc : base;
          state <= S_POW;
        end
        S_POW: begin
          pw  <= pw_next;
          rem <= rem - n_pass;
          if (rem == n_pass) begin
            r     <= '0;
            bi    <= BW'(M - 1);
            state <= S_MUL;
          end
        end
        S_MUL: begin
          r  <= r_next;
          bi <= bi - 1'b1;
          if (bi == '0) begin
            acc <= r_next;
            if (init_q) begin
              base   <= r_next;
              init_q <= 1'b0;
              state  <= S_PREP;
            end else begin
              u <= u + (cur_dbl ? u : UW'(1));
              if (step == SW'(CHAIN_LEN - 1)) state <= S_FIN;
              else begin
                step  <= step + 1'b1;
                state <= S_PREP;
              end
            end
          end
        end
        S_FIN: begin
          inv_out <= gf_sq(acc);
          done    <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_FINAL_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (u == TARGET)); // R2
  AST_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && base == '0) |-> (inv_out == '0)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(inv_out)); // R5
  AST_POW_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POW) |-> (rem != '0)); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && !init_q) |=> $stable(base)); // R7
  AST_TAKE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start) |=> (state != S_IDLE)); // R8
endmodule

// File: tb/gf_itoh_inverter_tb_top.sv
module gf_itoh_inverter_tb_top;
  localparam int M = 233;
  localparam logic [M-1:0] PL = (M'(1) << 74) | M'(1);
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [M-1:0] a_in = '0;
  logic [M-1:0] inv_out;
  logic         done;
  int checks = 0;
  int fails = 0;
  int ref_lat = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf_itoh_inverter dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_in(a_in), .inv_out(inv_out), .done(done)
  );

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [2*M-2:0] p;
    logic [2*M-2:0] xs;
    p  = '0;
    xs = {{(M-1){1'b0}}, x};
    for (int i = 0; i < M; i++) begin
      if (y[i]) p = p ^ xs;
      xs = xs << 1;
    end
    for (int i = 2*M-2; i >= M; i--)
      if (p[i]) begin
        p[i] = 1'b0;
        p[i-M +: M] = p[i-M +: M] ^ PL;
      end
    return p[M-1:0];
  endfunction

  function automatic logic [M-1:0] rand_elem();
    logic [M-1:0] v;
    v = '0;
    for (int i = 0; i < 8; i++) v = {v[M-33:0], $urandom()};
    if (v == '0) v = M'(1);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_lat(input int lat, input string req);
    if (ref_lat < 0) ref_lat = lat;
    checks++;
    if (lat != ref_lat) begin
      fails++;
      $display("FAIL %s latency actual=%0d expected=%0d", req, lat, ref_lat);
    end
  endtask

  task automatic wait_done(inout int lat);
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_inv(input logic [M-1:0] a, output logic [M-1:0] res, output int lat);
    @(negedge clk);
    a_in  = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    wait_done(lat);
    res = inv_out;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", M'(done), '0);
    chk(inv_out == '0, "R1 inv in reset", inv_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && inv_out == '0, "R1 after release", inv_out, '0);
  endtask

  task automatic t_known();
    logic [M-1:0] res, exp_x;
    int lat;
    run_inv(M'(1), res, lat);
    chk(res == M'(1), "R4 inverse of one", res, M'(1));
    chk_lat(lat, "R6 one");
    exp_x = (M'(1) << 232) | (M'(1) << 73);
    run_inv(M'(2), res, lat);
    chk(res == exp_x, "R4 inverse of x", res, exp_x);
    chk_lat(lat, "R6 x");
  endtask

  task automatic t_zero();
    logic [M-1:0] res;
    int lat;
    run_inv('0, res, lat);
    chk(res == '0, "R3 zero operand", res, '0);
    chk_lat(lat, "R6 zero");
  endtask

  task automatic t_random(input int n);
    logic [M-1:0] a, res, prod;
    int lat;
    for (int k = 0; k < n; k++) begin
      a = rand_elem();
      run_inv(a, res, lat);
      prod = ref_mul(a, res);
      chk(prod == M'(1), "R2 random product", prod, M'(1));
      chk_lat(lat, "R6 random");
    end
  endtask

  task automatic t_pulse();
    logic [M-1:0] a, res;
    int lat;
    bit steady;
    a = rand_elem();
    run_inv(a, res, lat);
    @(negedge clk);
    chk(done == 1'b0, "R5 done one cycle", M'(done), '0);
    steady = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (inv_out != res || done) steady = 1'b0;
    end
    chk(steady, "R5 output held", inv_out, res);
  endtask

  task automatic t_ignore();
    logic [M-1:0] a1, a2, prod;
    int lat;
    a1 = rand_elem();
    a2 = rand_elem() ^ M'(4);
    @(negedge clk);
    a_in  = a1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      lat++;
    end
    a_in  = a2;
    start = 1'b1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    a_in  = '0;
    wait_done(lat);
    prod = ref_mul(a1, inv_out);
    chk(prod == M'(1), "R7 busy start ignored", prod, M'(1));
    chk_lat(lat, "R7 busy start timing");
  endtask

  task automatic t_back_to_back();
    logic [M-1:0] a1, a2, r1, prod;
    int lat;
    a1 = rand_elem();
    a2 = rand_elem();
    run_inv(a1, r1, lat);
    chk(done == 1'b1, "R8 done seen", M'(done), M'(1));
    a_in  = a2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    wait_done(lat);
    prod = ref_mul(a1, r1);
    chk(prod == M'(1), "R8 first result", prod, M'(1));
    prod = ref_mul(a2, inv_out);
    chk(prod == M'(1), "R8 second result", prod, M'(1));
    chk_lat(lat, "R8 second latency");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_known();
    t_zero();
    t_random(6);
    t_pulse();
    t_ignore();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule